// File: doc/BRIEF.md
# Paged Address Translator with Process-Tagged TLB

This unit turns a logical byte address into a physical one for a system that uses fixed pages of 4096 bytes. The low 12 address bits are the offset within the page and pass through unchanged. The upper bits form the page number, which is looked up in an eight-entry fully associative lookaside buffer. Each entry is tagged with an address-space identifier, so translations that belong to different processes can sit side by side, and a context switch does not force a flush.

When the lookup hits, the physical address is returned one cycle after the request is accepted, and the page-table memory is not touched. When it misses, the page number is first compared with the page-table length. A page number that is too large traps without any memory access. Otherwise one 32-bit page-table entry is read from the table base plus four times the page number. A clear valid bit in that entry causes a trap. A set valid bit gives the frame number, which is installed in the buffer. Refills replace entries in round-robin order. Software can invalidate the whole buffer, or only the entries of one identifier.

Requests use a valid/ready handshake. The requester must hold the request stable until a one-cycle done or trap response comes back.

Top module: `pgx_xlate_unit`

## Requirements
- R1: The physical address on a done response is the frame number in bits 31:12 followed by bits 11:0 of the logical address, unchanged.
- R2: A request that hits in the buffer gives rsp_done in the cycle after acceptance, and no page-table read is made for it.
- R3: A hit needs both the page number and req_asid to match a valid entry. The same page number under another identifier misses. At most one entry matches at any time.
- R4: A miss whose page number is greater than or equal to ptlr gives rsp_trap with rsp_trap_kind = 0 in the cycle after acceptance, and no memory read is made.
- R5: Any other miss reads exactly one 32-bit entry at address ptbr + 4 × page number, which is word-aligned. Entry bit 0 is the valid bit and bits 31:12 hold the frame number.
- R6: A fetched entry with bit 0 clear gives rsp_trap with rsp_trap_kind = 1 and installs nothing, so repeating the same access reads memory again.
- R7: A fetched entry with bit 0 set is installed, and a done response follows in the next cycle. A later access to the same page and identifier hits.
- R8: The buffer holds 8 entries, and refills use them in round-robin order. The ninth refill after reset replaces the entry written by the first refill, whatever has been used since.
- R9: A one-cycle pulse on flush_all invalidates every entry.
- R10: A one-cycle pulse on flush_asid invalidates only the entries whose identifier equals flush_asid_id. Entries under other identifiers keep hitting.
- R11: req_ready is high only while the unit is idle. Each response lasts exactly one cycle, during which req_ready is low. rsp_done and rsp_trap are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle; request accepted on this edge |
| req_vaddr | input | 32 | Logical address |
| req_asid | input | 8 | Identifier of the requesting address space |
| ptbr | input | 32 | Byte address of the page table |
| ptlr | input | 20 | Number of pages the table covers |
| flush_all | input | 1 | Invalidate every buffer entry |
| flush_asid | input | 1 | Invalidate entries of one identifier |
| flush_asid_id | input | 8 | Identifier to invalidate |
| mem_rd_req | output | 1 | Page-table read request, held until acknowledged |
| mem_rd_addr | output | 32 | Page-table entry byte address |
| mem_rd_ack | input | 1 | Read data valid, one cycle |
| mem_rd_data | input | 32 | Page-table entry |
| rsp_done | output | 1 | Translation finished (one cycle) |
| rsp_trap | output | 1 | Translation faulted (one cycle) |
| rsp_trap_kind | output | 1 | 0 = beyond table length, 1 = entry invalid |
| rsp_paddr | output | 32 | Physical address, valid with rsp_done |

## Verification
The main function is exercised with several request patterns. A cold miss followed by a repeat of the same page separates the table walk from the hit path, and the two are told apart by counting memory reads. The same page under a second identifier shows that the identifier is part of the match. Pages that sit just below and exactly at the table length separate the length trap from a normal walk, while pages whose entries are marked invalid show that a fault installs nothing. A run of distinct refills that wraps the replacement pointer, followed by flushes that target one identifier or all entries, shows which entries survive each kind of eviction.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int PG_OFF_W = 12;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_RESP = 2'd2
  } walk_st_e;

  localparam logic TRAP_LEN = 1'b0;
  localparam logic TRAP_INV = 1'b1;
endpackage

// File: rtl/pgx_tlb.sv
module pgx_tlb #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              fl_all,
  input  logic              fl_asid,
  input  logic [ASID_W-1:0] fl_asid_id,
  input  logic              wr_en,
  input  logic [PFN_W-1:0]  wr_pfn,
  output logic              hit,
  output logic [PFN_W-1:0]  hit_pfn,
  output logic [N-1:0]      hit_vec,
  output logic [N-1:0]      valid_vec
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0]  rr_q;
  logic [VPN_W-1:0]  e_vpn  [N];
  logic [ASID_W-1:0] e_asid [N];
  logic [PFN_W-1:0]  e_pfn  [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    assign hit_vec[i] = valid_vec[i] && (e_vpn[i] == lk_vpn) && (e_asid[i] == lk_asid);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_vec[i] <= 1'b0;
        e_vpn[i]     <= '0;
        e_asid[i]    <= '0;
        e_pfn[i]     <= '0;
      end else begin
        if (fl_all || (fl_asid && e_asid[i] == fl_asid_id))
          valid_vec[i] <= 1'b0;
        if (wr_en && rr_q == IDX_W'(i)) begin
          valid_vec[i] <= 1'b1;
          e_vpn[i]     <= lk_vpn;
          e_asid[i]    <= lk_asid;
          e_pfn[i]     <= wr_pfn;
        end
      end
    end
  end

  always_comb begin
    hit_pfn = '0;
    for (int k = 0; k < N; k++)
      if (hit_vec[k]) hit_pfn = hit_pfn | e_pfn[k];
  end
  assign hit = |hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rr_q <= '0;
    else if (wr_en)
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/pgx_walk_ctl.sv
module pgx_walk_ctl
  import pgx_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int PA_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [VPN_W-1:0]    vpn,
  input  logic [PG_OFF_W-1:0] off,
  input  logic [PA_W-1:0]     ptbr,
  input  logic [VPN_W-1:0]    ptlr,
  input  logic                tlb_hit,
  input  logic [PFN_W-1:0]    tlb_pfn,
  input  logic                mem_rd_ack,
  input  logic [31:0]         mem_rd_data,
  output logic                req_ready,
  output logic                mem_rd_req,
  output logic [PA_W-1:0]     mem_rd_addr,
  output logic                refill_en,
  output logic [PFN_W-1:0]    refill_pfn,
  output logic                ev_accept,
  output logic                ev_len_fault,
  output logic                rsp_done,
  output logic                rsp_trap,
  output logic                rsp_trap_kind,
  output logic [PA_W-1:0]     rsp_paddr
);
  function automatic logic [PA_W-1:0] pte_addr(input logic [PA_W-1:0] base,
                                               input logic [VPN_W-1:0] page);
    return base + PA_W'({page, 2'b00});
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PFN_W-1:0] frame,
                                              input logic [PG_OFF_W-1:0] ofs);
    return {frame, ofs};
  endfunction

  walk_st_e        st_q;
  logic            trap_q, kind_q;
  logic [PA_W-1:0] pa_q;
  logic            pte_ok;

  assign req_ready    = (st_q == ST_IDLE);
  assign ev_accept    = req_valid && req_ready;
  assign ev_len_fault = (vpn >= ptlr);
  assign mem_rd_req   = (st_q == ST_WALK);
  assign mem_rd_addr  = pte_addr(ptbr, vpn);
  assign pte_ok       = mem_rd_data[0];
  assign refill_pfn   = mem_rd_data[PG_OFF_W +: PFN_W];
  assign refill_en    = mem_rd_req && mem_rd_ack && pte_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      trap_q <= 1'b0;
      kind_q <= TRAP_LEN;
      pa_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (ev_accept) begin
          if (tlb_hit) begin
            pa_q   <= join_pa(tlb_pfn, off);
            trap_q <= 1'b0;
            st_q   <= ST_RESP;
          end else if (ev_len_fault) begin
            trap_q <= 1'b1;
            kind_q <= TRAP_LEN;
            st_q   <= ST_RESP;
          end else begin
            st_q <= ST_WALK;
          end
        end
        ST_WALK: if (mem_rd_ack) begin
          if (pte_ok) begin
            pa_q   <= join_pa(refill_pfn, off);
            trap_q <= 1'b0;
          end else begin
            trap_q <= 1'b1;
            kind_q <= TRAP_INV;
          end
          st_q <= ST_RESP;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_done      = (st_q == ST_RESP) && !trap_q;
  assign rsp_trap      = (st_q == ST_RESP) && trap_q;
  assign rsp_trap_kind = kind_q;
  assign rsp_paddr     = pa_q;
endmodule

// File: rtl/pgx_xlate_unit.sv
module pgx_xlate_unit
  import pgx_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int ASID_W = 8,
  parameter int TLB_N  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [ASID_W-1:0]     req_asid,
  input  logic [PA_W-1:0]       ptbr,
  input  logic [VA_W-PG_OFF_W-1:0] ptlr,
  input  logic                  flush_all,
  input  logic                  flush_asid,
  input  logic [ASID_W-1:0]     flush_asid_id,
  output logic                  mem_rd_req,
  output logic [PA_W-1:0]       mem_rd_addr,
  input  logic                  mem_rd_ack,
  input  logic [31:0]           mem_rd_data,
  output logic                  rsp_done,
  output logic                  rsp_trap,
  output logic                  rsp_trap_kind,
  output logic [PA_W-1:0]       rsp_paddr
);
  localparam int VPN_W = VA_W - PG_OFF_W;
  localparam int PFN_W = PA_W - PG_OFF_W;

  logic [VPN_W-1:0]    va_vpn;
  logic [PG_OFF_W-1:0] va_off;
  logic                tlb_hit;
  logic [PFN_W-1:0]    tlb_pfn;
  logic [TLB_N-1:0]    tlb_hit_vec, tlb_valid_vec;
  logic                refill_en;
  logic [PFN_W-1:0]    refill_pfn;
  logic                ev_accept, ev_len_fault;

  assign va_vpn = req_vaddr[VA_W-1:PG_OFF_W];
  assign va_off = req_vaddr[PG_OFF_W-1:0];

  pgx_tlb #(.N(TLB_N), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) tlb_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_vpn     (va_vpn),
    .lk_asid    (req_asid),
    .fl_all     (flush_all),
    .fl_asid    (flush_asid),
    .fl_asid_id (flush_asid_id),
    .wr_en      (refill_en),
    .wr_pfn     (refill_pfn),
    .hit        (tlb_hit),
    .hit_pfn    (tlb_pfn),
    .hit_vec    (tlb_hit_vec),
    .valid_vec  (tlb_valid_vec)
  );

  pgx_walk_ctl #(.VPN_W(VPN_W), .PFN_W(PFN_W), .PA_W(PA_W)) ctl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .vpn           (va_vpn),
    .off           (va_off),
    .ptbr          (ptbr),
    .ptlr          (ptlr),
    .tlb_hit       (tlb_hit),
    .tlb_pfn       (tlb_pfn),
    .mem_rd_ack    (mem_rd_ack),
    .mem_rd_data   (mem_rd_data),
    .req_ready     (req_ready),
    .mem_rd_req    (mem_rd_req),
    .mem_rd_addr   (mem_rd_addr),
    .refill_en     (refill_en),
    .refill_pfn    (refill_pfn),
    .ev_accept     (ev_accept),
    .ev_len_fault  (ev_len_fault),
    .rsp_done      (rsp_done),
    .rsp_trap      (rsp_trap),
    .rsp_trap_kind (rsp_trap_kind),
    .rsp_paddr     (rsp_paddr)
  );
endmodule

// File: rtl/pgx_xlate_chk.sv
module pgx_xlate_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int TLB_N = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             flush_all,
  input logic             mem_rd_req,
  input logic [PA_W-1:0]  mem_rd_addr,
  input logic             rsp_done,
  input logic             rsp_trap,
  input logic             rsp_trap_kind,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic             tlb_hit,
  input logic [TLB_N-1:0] tlb_hit_vec,
  input logic [TLB_N-1:0] tlb_valid_vec,
  input logic             refill_en,
  input logic             ev_accept,
  input logic             ev_len_fault
);
  p_offset_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> rsp_paddr[11:0] == req_vaddr[11:0]);

  p_hit_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && tlb_hit) |=> (rsp_done && !mem_rd_req));

  p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tlb_hit_vec));

  p_len_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !tlb_hit && ev_len_fault) |=> (rsp_trap && !rsp_trap_kind && !mem_rd_req));

  p_walk_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> mem_rd_addr[1:0] == 2'b00);

  p_refill_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refill_en |=> rsp_done);

  p_flush_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !refill_en) |=> tlb_valid_vec == '0);

  p_rsp_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_done && rsp_trap));

  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done || rsp_trap) |=> !(rsp_done || rsp_trap));

  p_rsp_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done || rsp_trap) |-> !req_ready);
endmodule

bind pgx_xlate_unit pgx_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .TLB_N(TLB_N)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .req_vaddr     (req_vaddr),
  .flush_all     (flush_all),
  .mem_rd_req    (mem_rd_req),
  .mem_rd_addr   (mem_rd_addr),
  .rsp_done      (rsp_done),
  .rsp_trap      (rsp_trap),
  .rsp_trap_kind (rsp_trap_kind),
  .rsp_paddr     (rsp_paddr),
  .tlb_hit       (tlb_hit),
  .tlb_hit_vec   (tlb_hit_vec),
  .tlb_valid_vec (tlb_valid_vec),
  .refill_en     (refill_en),
  .ev_accept     (ev_accept),
  .ev_len_fault  (ev_len_fault)
);

// File: tb/pgx_xlate_unit_tb_top.sv
`timescale 1ns/1ps
module pgx_xlate_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic [7:0]  req_asid;
  logic [31:0] ptbr;
  logic [19:0] ptlr;
  logic        flush_all, flush_asid;
  logic [7:0]  flush_asid_id;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_ack;
  logic [31:0] mem_rd_data;
  logic        rsp_done, rsp_trap, rsp_trap_kind;
  logic [31:0] rsp_paddr;

  int n_chk = 0;
  int n_bad = 0;
  int reads = 0;
  int lat   = 0;

  typedef struct packed {
    logic [1:0]  kind;   // 0 done, 1 length trap, 2 invalid trap
    logic [31:0] pa;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  pgx_xlate_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_asid(req_asid), .ptbr(ptbr), .ptlr(ptlr),
    .flush_all(flush_all), .flush_asid(flush_asid), .flush_asid_id(flush_asid_id),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
    .mem_rd_data(mem_rd_data), .rsp_done(rsp_done), .rsp_trap(rsp_trap),
    .rsp_trap_kind(rsp_trap_kind), .rsp_paddr(rsp_paddr)
  );

  // Page-table contents as a function of the byte address read.
  function automatic logic [31:0] pte_of(input logic [31:0] a);
    return {a[21:2] ^ 20'h5A5A5, 11'b0, (a[4:2] != 3'd5)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model: acknowledges each read two cycles after request.
  always @(posedge clk) begin
    mem_rd_ack <= 1'b0;
    if (rst_n && mem_rd_req && !mem_rd_ack) begin
      if (lat == 1) begin
        mem_rd_ack  <= 1'b1;
        mem_rd_data <= pte_of(mem_rd_addr);
        reads       <= reads + 1;
        lat         <= 0;
      end else lat <= lat + 1;
    end
  end

  // Monitor: compares each response against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && (rsp_done || rsp_trap)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected response", 64'(rsp_done), 64'd0);
      end else begin
        exp_t  e;
        string t;
        logic [1:0] got;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        got = rsp_done ? 2'd0 : (rsp_trap_kind ? 2'd2 : 2'd1);
        chk(got == e.kind, {t, " kind"}, 64'(got), 64'(e.kind));
        if (e.kind == 2'd0)
          chk(rsp_paddr == e.pa, {t, " paddr"}, 64'(rsp_paddr), 64'(e.pa));
      end
    end
  end

  task automatic xact(input logic [19:0] vpn, input logic [11:0] off, input logic [7:0] asid,
                      input int exp_reads, input string tag);
    exp_t e;
    logic [31:0] pte;
    int r0;
    if (vpn >= ptlr) begin
      e.kind = 2'd1; e.pa = '0;
    end else begin
      pte = pte_of(ptbr + {10'd0, vpn, 2'b00});
      e.kind = pte[0] ? 2'd0 : 2'd2;
      e.pa   = {pte[31:12], off};
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    r0 = reads;
    req_valid = 1'b1;
    req_vaddr = {vpn, off};
    req_asid  = asid;
    @(negedge clk);
    while (!(rsp_done || rsp_trap)) begin
      chk(!req_ready, "R11 ready low while busy", 64'(req_ready), 64'd0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(reads - r0 == exp_reads, {tag, " memory reads"}, 64'(reads - r0), 64'(exp_reads));
    @(negedge clk);
    chk(!rsp_done && !rsp_trap && req_ready, "R11 one-cycle response",
        64'({rsp_done, rsp_trap, req_ready}), 64'b001);
  endtask

  task automatic pulse_flush(input bit all, input logic [7:0] id);
    @(negedge clk);
    flush_all = all; flush_asid = !all; flush_asid_id = id;
    @(negedge clk);
    flush_all = 1'b0; flush_asid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_asid = '0;
    ptbr = 32'h0001_0000; ptlr = 20'd64;
    flush_all = 1'b0; flush_asid = 1'b0; flush_asid_id = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_done && !rsp_trap && !mem_rd_req, "R11 reset state",
        64'({req_ready, rsp_done, rsp_trap, mem_rd_req}), 64'b1000);
    rst_n = 1'b1;

    xact(20'd1,  12'h123, 8'd3, 1, "R5 R1 cold miss walk");
    xact(20'd1,  12'hFFF, 8'd3, 0, "R2 R7 hit after refill");
    xact(20'd1,  12'h000, 8'd4, 1, "R3 other identifier misses");
    xact(20'd5,  12'h010, 8'd3, 1, "R6 invalid entry trap");
    xact(20'd5,  12'h010, 8'd3, 1, "R6 invalid entry not installed");
    xact(20'd64, 12'h001, 8'd3, 0, "R4 page at length traps");
    xact(20'd63, 12'hABC, 8'd3, 1, "R4 page below length walks");
    pulse_flush(1'b0, 8'd4);
    xact(20'd1,  12'h456, 8'd3, 0, "R10 other identifier survives");
    xact(20'd1,  12'h456, 8'd4, 1, "R10 flushed identifier misses");
    xact(20'd10, 12'h001, 8'd3, 1, "R8 fill");
    xact(20'd11, 12'h002, 8'd3, 1, "R8 fill");
    xact(20'd12, 12'h003, 8'd3, 1, "R8 fill");
    xact(20'd14, 12'h004, 8'd3, 1, "R8 fill last slot");
    xact(20'd16, 12'h005, 8'd3, 1, "R8 ninth refill wraps");
    xact(20'd1,  12'h006, 8'd3, 1, "R8 first entry evicted");
    xact(20'd63, 12'h007, 8'd3, 0, "R8 third entry kept");
    xact(20'd10, 12'h008, 8'd3, 0, "R8 fifth entry kept");
    pulse_flush(1'b1, 8'd0);
    xact(20'd63, 12'h009, 8'd3, 1, "R9 miss after full flush");
    xact(20'd63, 12'h00A, 8'd3, 0, "R7 hit after refill");

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R11 every request answered", 64'(exp_q.size()), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule